// File: doc/BRIEF.md
# DMA Channel End-Signal Generator

This block is the sequencer of a single DMA channel. Once software has programmed a transfer count and a few control fields and armed the channel, it runs that many transfer units. Each unit is one bus read cycle followed by one bus write cycle. The bus tells the block that a cycle has finished through a one-clock `bus_done` pulse, given while the matching strobe is high. Address generation, arbitration between channels and memory are not part of this block.

A transfer can start in one of two ways. In software mode, one `sw_start` pulse runs every unit back to back. In peripheral mode, each `periph_req` pulse runs a single unit.

When the transfer finishes, the block drives an active-low end signal `end_n`. A 2-bit mode field chooses where that pulse falls:
- nowhere (mode 00);
- after the last read (mode 01);
- after the last write (mode 10);
- together with the one-clock completion interrupt (mode 11).

The end signal is never driven when the channel is peripheral-triggered. A separate active-low strobe `act_n` can mark the clock after every completed bus cycle.

Top module: `dma_end_gen`

## Requirements
- R1: After reset, `bus_rd` and `bus_wr` are low, `act_n`, `end_n` are high, `end_irq`, `busy` and `cfg_err` are low. The mode is 00 and the channel is disarmed.
- R2: A software-started transfer with count N>0 runs exactly N read cycles and N write cycles, alternating read then write. `bus_rd` and `bus_wr` are never high together.
- R3: Completion gives `end_irq` high for exactly one clock, in the clock after the `bus_done` of the last write. At that point `busy` is low and the channel is disarmed, so a later `sw_start` does nothing.
- R4: With mode 00, `end_n` stays high.
- R5: With mode 01 and software source, `end_n` is low for exactly one clock: the clock after the `bus_done` of the final read.
- R6: With mode 10 and software source, `end_n` is low for exactly one clock: the clock after the `bus_done` of the final write.
- R7: With mode 11 and software source, `end_n` is low for exactly one clock, in the same clock as `end_irq`. This also holds for a zero count.
- R8: With `cfg_periph`=1 (the peripheral source), each `periph_req` taken while idle runs one read/write unit. `end_n` stays high in every mode.
- R9: A configuration write while the channel is armed is ignored and sets `cfg_err`. A later accepted write (made while disarmed) clears `cfg_err`.
- R10: With the active-strobe enable set, `act_n` is low for one clock after each read or write `bus_done`. With it clear, `act_n` stays high.
- R11: A trigger with a count of zero runs no bus cycles. It raises `end_irq` in the next clock and disarms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | End-signal placement mode |
| cfg_count | input | CW | Number of transfer units |
| cfg_periph | input | 1 | Request source: 0 software, 1 peripheral |
| cfg_act_en | input | 1 | Enable for the active strobe |
| cfg_enable | input | 1 | Arms the channel |
| sw_start | input | 1 | Software start pulse |
| periph_req | input | 1 | Peripheral request pulse |
| bus_done | input | 1 | Current bus cycle finished |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| act_n | output | 1 | Active-low strobe after each bus cycle |
| end_n | output | 1 | Active-low transfer-end signal |
| end_irq | output | 1 | One-clock completion interrupt |
| busy | output | 1 | Sequencer not idle |
| cfg_err | output | 1 | A configuration write was rejected |

## Verification
A corrupted unit counter shows up on the bus straight away, as the wrong number of read/write pairs. It also moves `end_irq` and the mode 01 and 10 end pulses away from the final `bus_done`. A stuck or mis-latched mode or source register shows up one clock after the last read or write, as an end pulse that is missing, misplaced or extra. An arm bit that fails to clear is seen at the next `sw_start` as unexpected bus activity. An arm bit that fails to set shows up when `cfg_err` does not rise on the next write.

// File: rtl/dma_end_gen.sv
module dma_end_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_periph,
  input  logic          cfg_act_en,
  input  logic          cfg_enable,
  input  logic          sw_start,
  input  logic          periph_req,
  input  logic          bus_done,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          act_n,
  output logic          end_n,
  output logic          end_irq,
  output logic          busy,
  output logic          cfg_err
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           state;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic          src_q, act_q, en_q, err_q, end_lo, act_lo, irq_q;

  logic trig, rd_done, wr_done, last, fin, end_set;

  assign trig    = en_q && state == S_IDLE && (src_q ? periph_req : sw_start);
  assign rd_done = state == S_RD && bus_done;
  assign wr_done = state == S_WR && bus_done;
  assign last    = cnt_q == CW'(1);
  assign fin     = (trig && cnt_q == '0) || (wr_done && last);
  assign end_set = !src_q && ((mode_q == 2'b01 && rd_done && last) ||
                              (mode_q == 2'b10 && wr_done && last) ||
                              (mode_q == 2'b11 && fin));

  assign bus_rd  = state == S_RD;
  assign bus_wr  = state == S_WR;
  assign busy    = state != S_IDLE;
  assign act_n   = !act_lo;
  assign end_n   = !end_lo;
  assign end_irq = irq_q;
  assign cfg_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= 2'b00;
      cnt_q  <= '0;
      src_q  <= 1'b0;
      act_q  <= 1'b0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      end_lo <= 1'b0;
      act_lo <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= fin;
      end_lo <= end_set;
      act_lo <= act_q && (rd_done || wr_done);
      if (cfg_we) begin
        if (!en_q) begin
          mode_q <= cfg_mode;
          cnt_q  <= cfg_count;
          src_q  <= cfg_periph;
          act_q  <= cfg_act_en;
          en_q   <= cfg_enable;
          err_q  <= 1'b0;
        end else begin
          err_q  <= 1'b1;
        end
      end
      if (fin) en_q <= 1'b0;
      case (state)
        S_IDLE: if (trig && cnt_q != '0) state <= S_RD;
        S_RD:   if (bus_done) state <= S_WR;
        S_WR:   if (bus_done) begin
                  cnt_q <= cnt_q - CW'(1);
                  if (last || src_q) state <= S_IDLE;
                  else               state <= S_RD;
                end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_end_gen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_done,
  input logic          end_n,
  input logic          end_irq,
  input logic          busy,
  input logic          cfg_err,
  input logic          cfg_we,
  input logic [1:0]    mode_q,
  input logic          src_q,
  input logic          en_q,
  input logic [CW-1:0] cnt_q
);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |=> !end_irq);
  assert_irq_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> (!busy && !en_q));
  assert_mode0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> end_n);
  assert_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_done && cnt_q == CW'(1) && mode_q == 2'b01 && !src_q) |=> !end_n);
  assert_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_n && mode_q == 2'b11) |-> end_irq);
  assert_periph_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_q |-> end_n);
  assert_reject_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && en_q) |=> (cfg_err && $stable(mode_q)));
endmodule

bind dma_end_gen dma_end_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_done(bus_done), .end_n(end_n), .end_irq(end_irq), .busy(busy),
  .cfg_err(cfg_err), .cfg_we(cfg_we), .mode_q(mode_q), .src_q(src_q),
  .en_q(en_q), .cnt_q(cnt_q)
);

// File: tb/dma_end_gen_test.sv
`timescale 1ns/1ps
module dma_end_gen_test;
  localparam int CW  = 8;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_periph = 0, cfg_act_en = 0, cfg_enable = 0;
  logic [1:0] cfg_mode = 0;
  logic [CW-1:0] cfg_count = 0;
  logic sw_start = 0, periph_req = 0, bus_done = 0;
  logic bus_rd, bus_wr, act_n, end_n, end_irq, busy, cfg_err;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_end_gen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_count(cfg_count), .cfg_periph(cfg_periph), .cfg_act_en(cfg_act_en),
    .cfg_enable(cfg_enable), .sw_start(sw_start), .periph_req(periph_req),
    .bus_done(bus_done), .bus_rd(bus_rd), .bus_wr(bus_wr), .act_n(act_n),
    .end_n(end_n), .end_irq(end_irq), .busy(busy), .cfg_err(cfg_err)
  );

  // [8:7] mode, [6] peripheral source, [5] act enable, [4:1] count, [0] end pulse expected
  localparam logic [8:0] VEC [9] = '{
    {2'b00, 1'b0, 1'b1, 4'd3, 1'b0},
    {2'b01, 1'b0, 1'b0, 4'd3, 1'b1},
    {2'b10, 1'b0, 1'b1, 4'd1, 1'b1},
    {2'b11, 1'b0, 1'b0, 4'd4, 1'b1},
    {2'b01, 1'b1, 1'b1, 4'd2, 1'b0},
    {2'b11, 1'b1, 1'b0, 4'd2, 1'b0},
    {2'b11, 1'b0, 1'b0, 4'd0, 1'b1},
    {2'b01, 1'b0, 1'b1, 4'd0, 1'b0},
    {2'b10, 1'b0, 1'b0, 4'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] m, input logic p, input logic a,
                           input int n, input logic en);
    @(negedge clk);
    cfg_we = 1; cfg_mode = m; cfg_periph = p; cfg_act_en = a;
    cfg_count = CW'(n); cfg_enable = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic go(input logic [1:0] m, input logic p, input logic a,
                    input int n, input bit expend);
    int cyc = 0, rds = 0, wrs = 0, lastrd = -1, lastwr = -1;
    int irqc = 0, irqat = -1, endc = 0, endat = -1, actc = 0, wt = 0, post = -1;
    int left = n;
    bit ov = 0;
    int exp_at;
    string tag;
    @(negedge clk);
    if (!p) sw_start = 1;
    else begin periph_req = 1; left--; end
    while (cyc < 400 && !(post >= 0 && cyc > post + 3)) begin
      @(negedge clk);
      cyc++;
      sw_start = 0;
      if (!end_n) begin endc++; endat = cyc; end
      if (end_irq) begin irqc++; irqat = cyc; end
      if (!act_n) actc++;
      if (bus_rd && bus_wr) ov = 1;
      if (periph_req) periph_req = 0;
      else if (p && !busy && left > 0) begin periph_req = 1; left--; end
      if (bus_rd || bus_wr) begin
        if (wt == LAT - 1) begin
          bus_done = 1; wt = 0;
          if (bus_rd) begin rds++; lastrd = cyc; end
          else begin wrs++; lastwr = cyc; end
        end else begin
          bus_done = 0; wt++;
        end
      end else begin
        bus_done = 0; wt = 0;
      end
      if (irqc > 0 && post < 0) post = cyc;
    end
    bus_done = 0;
    chk(rds == n, n == 0 ? "R11 reads" : "R2 reads", rds, n);
    chk(wrs == n, n == 0 ? "R11 writes" : "R2 writes", wrs, n);
    chk(!ov, "R2 strobe overlap", ov, 0);
    chk(irqc == 1, "R3 irq pulse count", irqc, 1);
    exp_at = (n == 0) ? 1 : lastwr + 1;
    chk(irqat == exp_at, n == 0 ? "R11 irq timing" : "R3 irq timing", irqat, exp_at);
    chk(!busy, "R3 idle after completion", busy, 0);
    tag = p ? "R8 end pulses" : (m == 0) ? "R4 end pulses" : (m == 1) ? "R5 end pulses" :
          (m == 2) ? "R6 end pulses" : "R7 end pulses";
    chk(endc == int'(expend), tag, endc, int'(expend));
    if (expend) begin
      exp_at = (m == 1) ? lastrd + 1 : (m == 2) ? lastwr + 1 : irqat;
      tag = (m == 1) ? "R5 end timing" : (m == 2) ? "R6 end timing" : "R7 end timing";
      chk(endat == exp_at, tag, endat, exp_at);
    end
    chk(actc == (a ? 2 * n : 0), "R10 active strobes", actc, a ? 2 * n : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_rd && !bus_wr, "R1 strobes at reset", {bus_rd, bus_wr}, 0);
    chk(act_n && end_n, "R1 active-low outputs at reset", {act_n, end_n}, 3);
    chk(!end_irq && !busy && !cfg_err, "R1 status at reset", {end_irq, busy, cfg_err}, 0);
    rst_n = 1;
    @(negedge clk);
    sw_start = 1;
    repeat (2) @(negedge clk);
    sw_start = 0;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd && !end_irq, "R1 disarmed after reset", busy, 0);

    foreach (VEC[i]) begin
      cfg_write(VEC[i][8:7], VEC[i][6], VEC[i][5], int'(VEC[i][4:1]), 1'b1);
      go(VEC[i][8:7], VEC[i][6], VEC[i][5], int'(VEC[i][4:1]), VEC[i][0]);
    end

    cfg_write(2'b00, 1'b0, 1'b0, 2, 1'b1);
    chk(!cfg_err, "R9 accepted write leaves error clear", cfg_err, 0);
    cfg_write(2'b11, 1'b0, 1'b1, 5, 1'b1);
    chk(cfg_err, "R9 rejected write sets error", cfg_err, 1);
    go(2'b00, 1'b0, 1'b0, 2, 1'b0);
    cfg_write(2'b01, 1'b0, 1'b0, 1, 1'b0);
    chk(!cfg_err, "R9 accepted write clears error", cfg_err, 0);

    cfg_write(2'b10, 1'b0, 1'b0, 2, 1'b1);
    go(2'b10, 1'b0, 1'b0, 2, 1'b1);
    @(negedge clk);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    repeat (4) begin
      @(negedge clk);
      chk(!busy && !bus_rd && !end_irq, "R3 disarmed ignores start", busy, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule